// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is a multiply-accumulate datapath that owns a pair of accumulator registers, called HI and LO. Each accepted operation supplies a 16-bit operation word and two 64-bit operands. The operand values are the values an integer register file would hold. The block decodes the word into a set of mode flags: accumulate, subtract, unsigned, saturate, short operands, the accumulator layout and the HI/LO read-out select. It then computes accumulator plus or minus the product, applies saturation if that mode is on, and updates HI and LO. The same cycle it can write the updated HI or LO to a destination register index.

The accumulator has two layouts:
- In the split layout, the 64-bit accumulator is the low half of HI joined to the low half of LO.
- In the double layout, the accumulator is the whole of LO.

Operand range rules depend on the mode. A value outside the allowed range raises a one-cycle error and leaves all state untouched. Signed and unsigned saturation follow different rules.

Top module: `mac_unit`

## Requirements
- R1: During reset, and in the first cycle after it, HI and LO read zero and neither `wr_valid` nor `op_error` is asserted.
- R2: A word whose bits 5:1 are 10100 and bits 8:7 are 00 is a saturable accumulate. It always accumulates and adds. Bit 0 set selects the double layout. Bit 10 turns on saturation and also forces short operands. Bit 9 selects HI for read-out. Bit 6 selects unsigned.
- R3: A word with bit 10 = 0, bit 6 = 1 and bits 5:1 = 01100 is a second family. Bits 8:6 = 001 is multiply, 011 is negated multiply (zero minus product), 101 is multiply-add and 111 is multiply-subtract. Bit 9 is the HI select and bit 0 is unsigned. This family always uses the split layout, 32-bit operands and no saturation.
- R4: An operation word that matches neither family has no effect. HI, LO, `wr_valid` and `op_error` behave as if no operation were issued.
- R5: The left-hand side is 0 without accumulate. In the double layout it is the 64-bit LO. Otherwise it is {HI[31:0], LO[31:0]}. The result is the left-hand side plus the product, or minus it when subtract is set.
- R6: Operand legality depends on the mode:
  - With 32-bit operands, each operand must equal the sign extension of its low 32 bits.
  - With short unsigned operands, each must be below 2^16.
  - With short signed operands, each must equal the sign extension of its low 16 bits.
  
  A violation pulses `op_error` for one cycle and changes neither HI, LO nor the write port.
- R7: The product is computed from the low 32 bits of each operand. It is a signed product of the sign-extended halves, or, when unsigned is set, an unsigned product of the zero-extended halves. The product is kept to 64 bits.
- R8: With signed saturation, a result that is not the sign extension of its low 32 bits is clamped. It becomes 0x000000007FFFFFFF if bit 63 is 0, or 0xFFFFFFFF80000000 if bit 63 is 1.
- R9: With unsigned saturation, a result with any of bits 63:32 set becomes all ones. Otherwise the result is kept unchanged.
- R10: In the double layout, LO takes the full result and HI keeps its value. In the split layout, LO takes the sign-extended result bits 31:0 and HI takes the sign-extended result bits 63:32.
- R11: The destination index is word bits 15:11. When it is nonzero, `wr_valid` asserts with that index and the updated HI (bit 9 set) or the updated LO (bit 9 clear). Index 0 suppresses the write.
- R12: HI, LO, `wr_valid`, `wr_index`, `wr_data` and `op_error` change only at the clock edge that accepts an operation. Their new values are visible from that edge until the next one. Back-to-back operations are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_word | input | 16 | Operation word: mode fields and destination index |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| wr_valid | output | 1 | Destination write strobe |
| wr_index | output | 5 | Destination register index |
| wr_data | output | 64 | Updated HI or LO for the destination |
| op_error | output | 1 | One-cycle pulse: operand out of range |
| acc_hi | output | 64 | HI accumulator register |
| acc_lo | output | 64 | LO accumulator register |

## Verification
Every result of an accepted operation is due at the clock edge that captures it. This covers the HI/LO update, the write strobe with its index and data, and the error pulse. The results are therefore sampled at the falling edge right after that capture edge. The driver stamps each expected item with the cycle number of that capture edge. The monitor pops an item only when the cycle counter reaches its stamp. In every cycle with nothing due, the monitor checks that HI and LO still match the model and that no write or error appears, which covers ignored words and idle cycles.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DST_W = 5;

  typedef struct packed {
    logic             acc;
    logic             sub;
    logic             uns;
    logic             sat;
    logic             shrt;
    logic             dbl;
    logic             hi_sel;
    logic [DST_W-1:0] dst;
  } mac_ctrl_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [15:0] word,
  output mac_ctrl_t   ctrl,
  output logic        recog
);
  logic fam_sat;
  logic fam_mul;

  // saturable accumulate family: low field 10100x, bits 8:7 clear
  assign fam_sat = (word[5:1] == 5'b10100) && (word[8:7] == 2'b00);
  // multiply family: bit 10 clear, bit 6 set, bits 5:1 = 01100
  assign fam_mul = !word[10] && word[6] && (word[5:1] == 5'b01100);

  assign recog = fam_sat || fam_mul;

  always_comb begin
    ctrl        = '0;
    ctrl.dst    = word[15:11];
    ctrl.hi_sel = word[9];
    if (fam_sat) begin
      ctrl.acc  = 1'b1;
      ctrl.sub  = 1'b0;
      ctrl.uns  = word[6];
      ctrl.sat  = word[10];
      ctrl.shrt = word[10];
      ctrl.dbl  = word[0];
    end else if (fam_mul) begin
      ctrl.acc  = word[8];
      ctrl.sub  = word[7];
      ctrl.uns  = word[0];
    end
  end
endmodule

// File: rtl/mac_opcheck.sv
module mac_opcheck #(
  parameter int HALF_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic [2*HALF_W-1:0] a,
  input  logic [2*HALF_W-1:0] b,
  input  logic                uns,
  input  logic                shrt,
  output logic                legal
);
  localparam int DATA_W = 2 * HALF_W;

  logic [1:0] ok;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    logic [DATA_W-1:0] v;
    logic [DATA_W-1:0] sx_half;
    logic [DATA_W-1:0] sx_short;
    logic [DATA_W-1:0] zx_short;
    assign v        = (i == 0) ? a : b;
    assign sx_half  = {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
    assign sx_short = {{(DATA_W-SHORT_W){v[SHORT_W-1]}}, v[SHORT_W-1:0]};
    assign zx_short = {{(DATA_W-SHORT_W){1'b0}}, v[SHORT_W-1:0]};
    always_comb begin
      if (!shrt)    ok[i] = (v == sx_half);
      else if (uns) ok[i] = (v == zx_short);
      else          ok[i] = (v == sx_short);
    end
  end

  assign legal = &ok;
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0]   a_lo,
  input  logic [HALF_W-1:0]   b_lo,
  input  logic [2*HALF_W-1:0] lhs,
  input  logic                uns,
  input  logic                sub,
  input  logic                sat,
  output logic [2*HALF_W-1:0] res
);
  localparam int DATA_W = 2 * HALF_W;
  localparam logic [DATA_W-1:0] POS_MAX = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  logic [DATA_W-1:0] mx, my, prod, raw;

  assign mx   = uns ? {{HALF_W{1'b0}}, a_lo} : {{HALF_W{a_lo[HALF_W-1]}}, a_lo};
  assign my   = uns ? {{HALF_W{1'b0}}, b_lo} : {{HALF_W{b_lo[HALF_W-1]}}, b_lo};
  // low DATA_W bits of the product are the same for both signednesses
  assign prod = mx * my;
  assign raw  = sub ? (lhs - prod) : (lhs + prod);

  always_comb begin
    res = raw;
    if (sat) begin
      if (uns) begin
        if (raw[DATA_W-1:HALF_W] != '0) res = '1;
      end else if (raw != {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]}) begin
        res = raw[DATA_W-1] ? NEG_MIN : POS_MAX;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int HALF_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [15:0]         op_word,
  input  logic [2*HALF_W-1:0] src_a,
  input  logic [2*HALF_W-1:0] src_b,
  output logic                wr_valid,
  output logic [DST_W-1:0]    wr_index,
  output logic [2*HALF_W-1:0] wr_data,
  output logic                op_error,
  output logic [2*HALF_W-1:0] acc_hi,
  output logic [2*HALF_W-1:0] acc_lo
);
  localparam int DATA_W = 2 * HALF_W;

  mac_ctrl_t         ctrl;
  logic              recog, legal, accept;
  logic [DATA_W-1:0] hi_q, lo_q, lhs, res, hi_n, lo_n;

  mac_decode u_dec (
    .word  (op_word),
    .ctrl  (ctrl),
    .recog (recog)
  );

  mac_opcheck #(.HALF_W(HALF_W), .SHORT_W(SHORT_W)) u_chk_op (
    .a     (src_a),
    .b     (src_b),
    .uns   (ctrl.uns),
    .shrt  (ctrl.shrt),
    .legal (legal)
  );

  always_comb begin
    if (!ctrl.acc)     lhs = '0;
    else if (ctrl.dbl) lhs = lo_q;
    else               lhs = {hi_q[HALF_W-1:0], lo_q[HALF_W-1:0]};
  end

  mac_arith #(.HALF_W(HALF_W)) u_arith (
    .a_lo (src_a[HALF_W-1:0]),
    .b_lo (src_b[HALF_W-1:0]),
    .lhs  (lhs),
    .uns  (ctrl.uns),
    .sub  (ctrl.sub),
    .sat  (ctrl.sat),
    .res  (res)
  );

  always_comb begin
    if (ctrl.dbl) begin
      lo_n = res;
      hi_n = hi_q;
    end else begin
      lo_n = {{HALF_W{res[HALF_W-1]}}, res[HALF_W-1:0]};
      hi_n = {{HALF_W{res[DATA_W-1]}}, res[DATA_W-1:HALF_W]};
    end
  end

  assign accept = op_valid && recog;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      wr_valid <= 1'b0;
      wr_index <= '0;
      wr_data  <= '0;
      op_error <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      op_error <= 1'b0;
      if (accept) begin
        if (!legal) begin
          op_error <= 1'b1;
        end else begin
          hi_q <= hi_n;
          lo_q <= lo_n;
          if (ctrl.dst != '0) begin
            wr_valid <= 1'b1;
            wr_index <= ctrl.dst;
            wr_data  <= ctrl.hi_sel ? hi_n : lo_n;
          end
        end
      end
    end
  end

  assign acc_hi = hi_q;
  assign acc_lo = lo_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                op_valid,
  input logic                wr_valid,
  input logic [4:0]          wr_index,
  input logic [2*HALF_W-1:0] wr_data,
  input logic                op_error,
  input logic [2*HALF_W-1:0] acc_hi,
  input logic [2*HALF_W-1:0] acc_lo
);
  logic started;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    op_error |-> !wr_valid); // R6

  AST_ERR_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (started && op_error) |-> ($stable(acc_hi) && $stable(acc_lo))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(op_valid)) |->
      (!wr_valid && !op_error && $stable(acc_hi) && $stable(acc_lo))); // R12

  AST_WR_NONZERO_IDX: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_index != 5'd0)); // R11

  AST_WR_FROM_ACC: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ((wr_data == acc_hi) || (wr_data == acc_lo))); // R11
endmodule

bind mac_unit mac_unit_chk #(.HALF_W(HALF_W)) u_mac_unit_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .wr_valid (wr_valid),
  .wr_index (wr_index),
  .wr_data  (wr_data),
  .op_error (op_error),
  .acc_hi   (acc_hi),
  .acc_lo   (acc_lo)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] op_word = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        wr_valid, op_error;
  logic [4:0]  wr_index;
  logic [63:0] wr_data, acc_hi, acc_lo;

  always #4 clk = ~clk; // 125 MHz

  mac_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .src_a(src_a), .src_b(src_b), .wr_valid(wr_valid), .wr_index(wr_index),
    .wr_data(wr_data), .op_error(op_error), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  typedef struct {
    int          due;
    logic        wv;
    logic [4:0]  idx;
    logic [63:0] wd;
    logic        err;
    logic [63:0] hi;
    logic [63:0] lo;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          checks = 0;
  int          failures = 0;
  logic [63:0] mh = '0, ml = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] sx32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction
  function automatic logic [63:0] sx16(input logic [63:0] v);
    return {{48{v[15]}}, v[15:0]};
  endfunction

  function automatic exp_t model(input logic [15:0] w, input logic [63:0] a,
                                 input logic [63:0] b);
    exp_t e;
    logic fa, fb, acc, sub, uns, sat, sh, dbl, ok;
    logic [63:0] lhs, pa, pb, pr, r, nh, nl;
    e.due = 0; e.wv = 0; e.idx = w[15:11]; e.wd = '0; e.err = 0; e.tag = "";
    fa = (w[5:1] == 5'b10100) && (w[8:7] == 2'b00);
    fb = !w[10] && w[6] && (w[5:1] == 5'b01100);
    acc = 0; sub = 0; uns = 0; sat = 0; sh = 0; dbl = 0;
    if (fa) begin
      acc = 1; uns = w[6]; sat = w[10]; sh = w[10]; dbl = w[0];
    end else if (fb) begin
      acc = w[8]; sub = w[7]; uns = w[0];
    end
    if (fa || fb) begin
      if (!sh)      ok = (a == sx32(a)) && (b == sx32(b));
      else if (uns) ok = (a[63:16] == 0) && (b[63:16] == 0);
      else          ok = (a == sx16(a)) && (b == sx16(b));
      if (!ok) e.err = 1;
      else begin
        lhs = !acc ? 64'd0 : dbl ? ml : {mh[31:0], ml[31:0]};
        pa = uns ? {32'd0, a[31:0]} : sx32(a);
        pb = uns ? {32'd0, b[31:0]} : sx32(b);
        pr = pa * pb;
        r  = sub ? lhs - pr : lhs + pr;
        if (sat && uns && r[63:32] != 0) r = '1;
        else if (sat && !uns && r != sx32(r))
          r = r[63] ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
        if (dbl) begin nl = r; nh = mh; end
        else begin nl = sx32(r); nh = {{32{r[63]}}, r[63:32]}; end
        mh = nh; ml = nl;
        e.wv = (w[15:11] != 0);
        e.wd = w[9] ? nh : nl;
      end
    end
    e.hi = mh; e.lo = ml;
    return e;
  endfunction

  function automatic logic [15:0] wa(input logic dbl, input logic sat,
      input logic hs, input logic uns, input logic [4:0] rd);
    return {rd, sat, hs, 2'b00, uns, 5'b10100, dbl};
  endfunction
  function automatic logic [15:0] wb(input logic [2:0] op, input logic hs,
      input logic uns, input logic [4:0] rd);
    return {rd, 1'b0, hs, op, 5'b01100, uns};
  endfunction

  task automatic issue(input logic [15:0] w, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    exp_t e;
    @(posedge clk); #2;
    op_valid = 1; op_word = w; src_a = a; src_b = b;
    e = model(w, a, b);
    e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      op_valid = 0; op_word = '0; src_a = '0; src_b = '0;
    end
  endtask

  // monitor: compares due items, otherwise checks quiet outputs
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wr_valid !== e.wv || op_error !== e.err || acc_hi !== e.hi ||
            acc_lo !== e.lo || (e.wv && (wr_index !== e.idx || wr_data !== e.wd))) begin
          failures++;
          $display("FAIL %s: got wv=%0b idx=%0d wd=%h err=%0b hi=%h lo=%h exp wv=%0b idx=%0d wd=%h err=%0b hi=%h lo=%h",
                   e.tag, wr_valid, wr_index, wr_data, op_error, acc_hi, acc_lo,
                   e.wv, e.idx, e.wd, e.err, e.hi, e.lo);
        end
      end else if (q.size() == 0) begin
        checks++;
        if (wr_valid !== 1'b0 || op_error !== 1'b0 || acc_hi !== mh || acc_lo !== ml) begin
          failures++;
          $display("FAIL R12 idle: got wv=%0b err=%0b hi=%h lo=%h exp wv=0 err=0 hi=%h lo=%h",
                   wr_valid, op_error, acc_hi, acc_lo, mh, ml);
        end
      end
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: got cycle=%0d exp below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    checks++;
    if (acc_hi !== 0 || acc_lo !== 0 || wr_valid !== 0 || op_error !== 0) begin
      failures++;
      $display("FAIL R1 reset: got hi=%h lo=%h wv=%0b err=%0b exp all zero",
               acc_hi, acc_lo, wr_valid, op_error);
    end

    // R3 R7 signed and unsigned multiply
    issue(wb(3'b001, 0, 0, 5'd3), -64'sd3, 64'd7, "R7 signed mul");
    issue(wb(3'b001, 1, 1, 5'd4), '1, 64'd2, "R7 unsigned mul hi");
    idle(1);
    // R5 accumulate from split pair
    issue(wb(3'b101, 0, 0, 5'd5), 64'd10, 64'd10, "R5 macc split lhs");
    issue(wb(3'b111, 1, 0, 5'd5), 64'd1000, -64'sd3, "R3 msac");
    issue(wb(3'b011, 0, 0, 5'd6), 64'd5, 64'd6, "R3 negated mul");
    idle(1);
    // R6 illegal 32-bit operand
    issue(wb(3'b001, 0, 0, 5'd2), 64'h1_0000_0000, 64'd1, "R6 wide operand");
    idle(1);
    // R11 index zero, clears acc
    issue(wb(3'b001, 0, 0, 5'd0), 64'd0, 64'd0, "R11 index zero");
    // R8 positive clamp
    issue(wa(0, 1, 0, 0, 5'd7), 64'h7FFF, 64'h7FFF, "R8 sat step1");
    issue(wa(0, 1, 0, 0, 5'd7), 64'h7FFF, 64'h7FFF, "R8 sat step2");
    issue(wa(0, 1, 0, 0, 5'd7), 64'h7FFF, 64'h7FFF, "R8 positive clamp");
    issue(wa(0, 1, 0, 0, 5'd7), 64'h8000, 64'h1, "R6 short signed range");
    idle(1);
    // R8 negative clamp
    issue(wb(3'b001, 0, 0, 5'd0), 64'd0, 64'd0, "R11 clear");
    issue(wa(0, 1, 1, 0, 5'd8), 64'hFFFF_FFFF_FFFF_8000, 64'h7FFF, "R8 neg step1");
    issue(wa(0, 1, 1, 0, 5'd8), 64'hFFFF_FFFF_FFFF_8000, 64'h7FFF, "R8 neg step2");
    issue(wa(0, 1, 0, 0, 5'd8), 64'hFFFF_FFFF_FFFF_8000, 64'h7FFF, "R8 negative clamp");
    idle(1);
    // R9 unsigned saturation
    issue(wb(3'b001, 0, 0, 5'd0), 64'd0, 64'd0, "R11 clear");
    issue(wa(0, 1, 0, 1, 5'd9), 64'hFFFF, 64'hFFFF, "R9 uns step1");
    issue(wa(0, 1, 1, 1, 5'd9), 64'hFFFF, 64'hFFFF, "R9 unsigned all ones");
    issue(wa(0, 1, 0, 1, 5'd9), '1, 64'h1, "R6 short unsigned range");
    idle(1);
    // R10 double layout
    issue(wb(3'b001, 0, 1, 5'd0), '1, 64'd2, "R10 preload");
    issue(wa(1, 0, 1, 0, 5'd10), 64'd3, 64'd4, "R10 double keeps hi");
    issue(wa(1, 0, 0, 0, 5'd11), 64'd1, 64'd1, "R10 double lo");
    issue(wa(1, 1, 0, 0, 5'd11), 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, "R2 double sat short");
    issue(wb(3'b001, 1, 0, 5'd12), 64'h4000_0000, 64'd2, "R10 split sign ext");
    idle(1);
    // R4 unrecognised words
    issue(16'h0000, 64'd5, 64'd5, "R4 zero word");
    issue(wa(0, 0, 0, 0, 5'd3) | 16'h0080, 64'd5, 64'd5, "R4 bit7 set");
    issue(wb(3'b001, 0, 0, 5'd3) | 16'h0400, 64'd5, 64'd5, "R4 bit10 set");
    idle(1);
    // R12 back-to-back with R2 plain accumulate
    issue(wa(0, 0, 0, 0, 5'd13), 64'd100, 64'd3, "R12 b2b one");
    issue(wa(0, 0, 1, 1, 5'd14), '1, '1, "R2 unsigned accumulate");
    issue(wa(0, 0, 0, 0, 5'd15), -64'sd50, 64'd9, "R12 b2b three");
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule